// File: doc/BRIEF.md
# Hardware Breakpoint Comparator Unit

This block is the address-match part of an on-chip debug system for a small microcontroller core. In every cycle it looks at the instruction about to issue, at the instruction that has just retired, and at the retired instruction's data access. When an enabled condition matches, it raises a halt request. It has a fixed pool of four address comparators. One belongs to the debug controller for single-stepping. The other three are user slots. Each user slot can be configured as a program-address breakpoint or as a data-access breakpoint. Two adjacent slots can also be joined into a base/mask range breakpoint that watches either the retired program counter or the data address. A separate mode halts after any change of program flow.

Halts come in two timing classes. Program-address and single-step matches are checked against the issuing instruction. For these, `haltPre` is raised together with `haltReq`, and the core must not execute that instruction. Data, masked and flow matches are checked against the retired instruction, so the triggering instruction has already completed. A halt is sticky: once it fires, the unit stays halted and records its cause bits until the debug controller pulses `resume`. Configuration is written one slot per cycle. A write that would break the slot rules is dropped whole and raises an error flag.

Top module: `brk_unit`

## Requirements
- R1: After reset, `haltReq`, `haltPre`, `halted`, `haltCause` and `cfgErr` are 0. All user slots are off, flow mode is off and the step slot is disarmed, so no stimulus raises a halt.
- R2: A write to `cfgSlot` 0..2 sets that slot's role from `cfgRole` and its address from `cfgAddr`. The role codes are 0 off, 1 program, 2 data read, 3 data write, 4 data read-or-write, 5 masked on PC and 6 masked on data. A write to `cfgSlot` 3 sets flow mode on or off from `cfgRole` bit 0 and is always accepted.
- R3: A program slot raises `haltReq` and `haltPre` in the same cycle in which `issueValid` is high and `issuePc` equals the slot address.
- R4: A data slot matches when `retireValid` is high and `retireDAddr` equals its address. A read slot needs `retireRd`, a write slot needs `retireWr`, and a read-or-write slot needs either one. The halt has `haltPre` low.
- R5: No data slot and no masked-on-data pair ever matches a data address below 32 (0x00 to 0x1F).
- R6: A masked write to slot k loads the base into slot k from `cfgAddr` and the mask into slot k+1 from `cfgMask`. It matches a retired address when ((address XOR base) AND mask) == 0. The PC form uses `retirePc`. The data form needs a read or a write. Both forms halt with `haltPre` low and set cause bit k.
- R7: When flow mode is on, `retireValid` together with `retireFlow` raises a halt with `haltPre` low and cause bit 4.
- R8: A `stepArm` pulse stores `stepPc` and arms the step slot. The first issuing instruction whose PC differs from that value raises a halt with `haltPre` and cause bit 3, and the step slot then disarms.
- R9: A halt request sets `halted` at the next edge. It also records every condition matching in that cycle in `haltCause` (bits 0..2 for the user slots, 3 for step, 4 for flow). Both hold until `resume`, which clears them. While halted, `haltReq` stays low.
- R10: A write that would leave more than two user slots in data roles is rejected.
- R11: A masked write to slot 2, a masked write whose partner slot k+1 holds any role other than off or its own mask, a write to a slot that is currently the mask half of a pair, and a write with role code 7 are all rejected.
- R12: A rejected write sets `cfgErr` and leaves every slot's role and address unchanged. An accepted write clears `cfgErr`.
- R13: When the base slot of a pair is rewritten with a non-masked role, its partner slot is freed (off) and can be configured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSlot | input | 2 | Target slot 0..2, or 3 for flow mode |
| cfgRole | input | 3 | Role code for the slot |
| cfgAddr | input | ADDR_W | Slot address or base address |
| cfgMask | input | ADDR_W | Mask for masked roles |
| stepArm | input | 1 | Arms the single-step slot |
| stepPc | input | ADDR_W | PC recorded when stepping is armed |
| resume | input | 1 | Leaves the halted state and clears the cause |
| issueValid | input | 1 | An instruction is about to execute |
| issuePc | input | ADDR_W | PC of the issuing instruction |
| retireValid | input | 1 | An instruction has completed |
| retirePc | input | ADDR_W | PC of the completed instruction |
| retireDAddr | input | ADDR_W | Data address it accessed |
| retireRd | input | 1 | It read data memory |
| retireWr | input | 1 | It wrote data memory |
| retireFlow | input | 1 | It changed program flow |
| haltReq | output | 1 | Halt request this cycle |
| haltPre | output | 1 | The halt is before the issuing instruction |
| halted | output | 1 | Sticky halted state |
| haltCause | output | 5 | Sticky cause bits |
| cfgErr | output | 1 | Last configuration write was rejected |

## Verification
The bench sweeps mask patterns over ranges of addresses. A design that ANDs the address with the mask before the compare, instead of masking the difference, breaks the all-zeros-mask case. It also sweeps data accesses from address 0 upward across the register-file boundary. A design that leaks matches below 32, or that confuses read and write mode, shows up there, and so does one that mixes up pre-execution and post-execution timing through `haltPre`. For the configuration rules, every illegal write is followed by a check that the old breakpoints still fire and that `cfgErr` is set. This catches partial updates, a third data slot slipping through, or a stale mask half after a pair is broken up. Stepping is checked for not firing on the armed PC and for disarming after its single halt.

// File: rtl/brk_pkg.sv
package brk_pkg;
  // number of user comparator slots (one more slot belongs to stepping)
  localparam int USER_SLOTS = 3;
  localparam int SEL_W      = $clog2(USER_SLOTS + 1);
  localparam int CNT_W      = $clog2(USER_SLOTS + 1);
  localparam int STEP_BIT   = USER_SLOTS;
  localparam int FLOW_BIT   = USER_SLOTS + 1;
  localparam int CAUSE_W    = USER_SLOTS + 2;
  localparam int FLOW_SEL   = USER_SLOTS;

  // external role codes 0..6; code 7 is only ever used internally
  typedef enum logic [2:0] {
    ROLE_OFF   = 3'd0,
    ROLE_PROG  = 3'd1,
    ROLE_DRD   = 3'd2,
    ROLE_DWR   = 3'd3,
    ROLE_DRW   = 3'd4,
    ROLE_MPC   = 3'd5,
    ROLE_MDATA = 3'd6,
    ROLE_MHALF = 3'd7
  } slotRole_e;

  // load strobes from control to datapath
  typedef struct packed {
    logic [USER_SLOTS-1:0] ldBase;
    logic [USER_SLOTS-1:0] ldMask;
    logic                  stepLoad;
  } dpStrobe_t;

  function automatic logic isDataRole(slotRole_e r);
    return (r == ROLE_DRD) || (r == ROLE_DWR) || (r == ROLE_DRW);
  endfunction

  function automatic logic isMaskRole(slotRole_e r);
    return (r == ROLE_MPC) || (r == ROLE_MDATA);
  endfunction
endpackage

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int RF_SIZE = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dpStrobe_t             strb,
  input  logic [ADDR_W-1:0]     cfgAddr,
  input  logic [ADDR_W-1:0]     cfgMask,
  input  logic [ADDR_W-1:0]     stepPc,
  input  logic [ADDR_W-1:0]     issuePc,
  input  logic [ADDR_W-1:0]     retirePc,
  input  logic [ADDR_W-1:0]     retireDAddr,
  output logic [USER_SLOTS-1:0] progEq,
  output logic [USER_SLOTS-1:0] dataEq,
  output logic [USER_SLOTS-1:0] pcMaskHit,
  output logic [USER_SLOTS-1:0] dataMaskHit,
  output logic                  stepMoved,
  output logic                  dataInRf
);
  localparam logic [ADDR_W-1:0] RF_LIMIT = ADDR_W'(RF_SIZE);

  logic [ADDR_W-1:0] slotAddr [USER_SLOTS];
  logic [ADDR_W-1:0] stepRef;

  // slot address registers; a base and a mask may load different slots
  for (genvar k = 0; k < USER_SLOTS; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slotAddr[k] <= '0;
      end else if (strb.ldBase[k]) begin
        slotAddr[k] <= cfgAddr;
      end else if (strb.ldMask[k]) begin
        slotAddr[k] <= cfgMask;
      end
    end

    assign progEq[k] = (issuePc == slotAddr[k]);
    assign dataEq[k] = (retireDAddr == slotAddr[k]);

    // a pair uses slot k as base and slot k+1 as mask
    if (k < USER_SLOTS - 1) begin : g_pair
      assign pcMaskHit[k]   = ((retirePc ^ slotAddr[k]) & slotAddr[k+1]) == '0;
      assign dataMaskHit[k] = ((retireDAddr ^ slotAddr[k]) & slotAddr[k+1]) == '0;
    end else begin : g_nopair
      assign pcMaskHit[k]   = 1'b0;
      assign dataMaskHit[k] = 1'b0;
    end
  end

  // reserved comparator used for single stepping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepRef <= '0;
    end else if (strb.stepLoad) begin
      stepRef <= stepPc;
    end
  end

  assign stepMoved = (issuePc != stepRef);
  assign dataInRf  = (retireDAddr < RF_LIMIT);
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
#(
  parameter int MAX_DATA = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfgWe,
  input  logic [SEL_W-1:0]      cfgSlot,
  input  logic [2:0]            cfgRole,
  input  logic                  stepArm,
  input  logic                  resume,
  input  logic                  issueValid,
  input  logic                  retireValid,
  input  logic                  retireRd,
  input  logic                  retireWr,
  input  logic                  retireFlow,
  input  logic [USER_SLOTS-1:0] progEq,
  input  logic [USER_SLOTS-1:0] dataEq,
  input  logic [USER_SLOTS-1:0] pcMaskHit,
  input  logic [USER_SLOTS-1:0] dataMaskHit,
  input  logic                  stepMoved,
  input  logic                  dataInRf,
  output dpStrobe_t             strb,
  output logic                  haltReq,
  output logic                  haltPre,
  output logic                  halted,
  output logic [CAUSE_W-1:0]    haltCause,
  output logic                  cfgErr
);
  localparam logic [CNT_W-1:0] DATA_LIMIT = CNT_W'(MAX_DATA);

  slotRole_e            roleQ [USER_SLOTS];
  logic                 flowEnQ;
  logic                 stepArmedQ;
  logic                 haltedQ;
  logic [CAUSE_W-1:0]   causeQ;
  logic                 errQ;

  // ---------------- configuration check ----------------
  slotRole_e            newRole;
  slotRole_e            ownRole;
  slotRole_e            partnerRole;
  logic                 partnerExists;
  logic [CNT_W-1:0]     dataOthers;
  logic                 flowSel;
  logic                 userSel;
  logic                 reject;
  logic                 accept;

  always_comb begin
    newRole       = slotRole_e'(cfgRole);
    ownRole       = ROLE_OFF;
    partnerRole   = ROLE_OFF;
    partnerExists = 1'b0;
    dataOthers    = '0;
    for (int k = 0; k < USER_SLOTS; k++) begin
      if (k == int'(cfgSlot)) begin
        ownRole = roleQ[k];
      end
      if (k == int'(cfgSlot) + 1) begin
        partnerRole   = roleQ[k];
        partnerExists = 1'b1;
      end
      if (k != int'(cfgSlot) && isDataRole(roleQ[k])) begin
        dataOthers = dataOthers + CNT_W'(1);
      end
    end

    flowSel = (cfgSlot == SEL_W'(FLOW_SEL));
    userSel = (int'(cfgSlot) < USER_SLOTS);

    reject = 1'b0;
    if (userSel) begin
      if (newRole == ROLE_MHALF) reject = 1'b1;
      if (ownRole == ROLE_MHALF) reject = 1'b1;
      if (isDataRole(newRole) && dataOthers >= DATA_LIMIT) reject = 1'b1;
      if (isMaskRole(newRole)) begin
        if (!partnerExists) begin
          reject = 1'b1;
        end else if (partnerRole != ROLE_OFF && partnerRole != ROLE_MHALF) begin
          reject = 1'b1;
        end
      end
    end
    accept = cfgWe && userSel && !reject;
  end

  // load strobes for the address registers
  always_comb begin
    strb.ldBase   = '0;
    strb.ldMask   = '0;
    strb.stepLoad = stepArm;
    for (int k = 0; k < USER_SLOTS; k++) begin
      strb.ldBase[k] = accept && (k == int'(cfgSlot));
      strb.ldMask[k] = accept && isMaskRole(newRole) && (k == int'(cfgSlot) + 1);
    end
  end

  // role table, flow enable and error flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < USER_SLOTS; k++) roleQ[k] <= ROLE_OFF;
      flowEnQ <= 1'b0;
      errQ    <= 1'b0;
    end else if (cfgWe) begin
      if (flowSel) begin
        flowEnQ <= cfgRole[0];
        errQ    <= 1'b0;
      end else if (accept) begin
        for (int k = 0; k < USER_SLOTS; k++) begin
          if (k == int'(cfgSlot)) begin
            roleQ[k] <= newRole;
          end else if (k == int'(cfgSlot) + 1) begin
            if (isMaskRole(newRole)) begin
              roleQ[k] <= ROLE_MHALF;
            end else if (isMaskRole(ownRole)) begin
              roleQ[k] <= ROLE_OFF;
            end
          end
        end
        errQ <= 1'b0;
      end else begin
        errQ <= 1'b1;
      end
    end
  end

  // ---------------- match combination ----------------
  logic [USER_SLOTS-1:0] preHit;
  logic [USER_SLOTS-1:0] postHit;
  logic                  anyAccess;
  logic                  stepHit;
  logic                  flowHit;
  logic [CAUSE_W-1:0]    hitVec;

  always_comb begin
    anyAccess = retireRd || retireWr;
    preHit    = '0;
    postHit   = '0;
    for (int k = 0; k < USER_SLOTS; k++) begin
      unique case (roleQ[k])
        ROLE_PROG:  preHit[k]  = issueValid && progEq[k];
        ROLE_DRD:   postHit[k] = retireValid && retireRd && dataEq[k] && !dataInRf;
        ROLE_DWR:   postHit[k] = retireValid && retireWr && dataEq[k] && !dataInRf;
        ROLE_DRW:   postHit[k] = retireValid && anyAccess && dataEq[k] && !dataInRf;
        ROLE_MPC:   postHit[k] = retireValid && pcMaskHit[k];
        ROLE_MDATA: postHit[k] = retireValid && anyAccess && dataMaskHit[k] && !dataInRf;
        default:    ;
      endcase
    end
    stepHit = stepArmedQ && issueValid && stepMoved;
    flowHit = flowEnQ && retireValid && retireFlow;
    hitVec  = {flowHit, stepHit, preHit | postHit};
  end

  assign haltReq = !haltedQ && (hitVec != '0);
  assign haltPre = !haltedQ && (stepHit || (preHit != '0));

  // ---------------- halt state ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haltedQ <= 1'b0;
      causeQ  <= '0;
    end else if (haltedQ && resume) begin
      haltedQ <= 1'b0;
      causeQ  <= '0;
    end else if (haltReq) begin
      haltedQ <= 1'b1;
      causeQ  <= hitVec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepArmedQ <= 1'b0;
    end else if (stepArm) begin
      stepArmedQ <= 1'b1;
    end else if (haltReq && stepHit) begin
      stepArmedQ <= 1'b0;
    end
  end

  assign halted    = haltedQ;
  assign haltCause = causeQ;
  assign cfgErr    = errQ;
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RF_SIZE  = 32,
  parameter int MAX_DATA = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfgWe,
  input  logic [SEL_W-1:0]     cfgSlot,
  input  logic [2:0]           cfgRole,
  input  logic [ADDR_W-1:0]    cfgAddr,
  input  logic [ADDR_W-1:0]    cfgMask,
  input  logic                 stepArm,
  input  logic [ADDR_W-1:0]    stepPc,
  input  logic                 resume,
  input  logic                 issueValid,
  input  logic [ADDR_W-1:0]    issuePc,
  input  logic                 retireValid,
  input  logic [ADDR_W-1:0]    retirePc,
  input  logic [ADDR_W-1:0]    retireDAddr,
  input  logic                 retireRd,
  input  logic                 retireWr,
  input  logic                 retireFlow,
  output logic                 haltReq,
  output logic                 haltPre,
  output logic                 halted,
  output logic [CAUSE_W-1:0]   haltCause,
  output logic                 cfgErr
);
  dpStrobe_t             strb;
  logic [USER_SLOTS-1:0] progEq;
  logic [USER_SLOTS-1:0] dataEq;
  logic [USER_SLOTS-1:0] pcMaskHit;
  logic [USER_SLOTS-1:0] dataMaskHit;
  logic                  stepMoved;
  logic                  dataInRf;

  brk_datapath #(.ADDR_W(ADDR_W), .RF_SIZE(RF_SIZE)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .cfgAddr(cfgAddr), .cfgMask(cfgMask), .stepPc(stepPc),
    .issuePc(issuePc), .retirePc(retirePc), .retireDAddr(retireDAddr),
    .progEq(progEq), .dataEq(dataEq), .pcMaskHit(pcMaskHit),
    .dataMaskHit(dataMaskHit), .stepMoved(stepMoved), .dataInRf(dataInRf)
  );

  brk_ctrl #(.MAX_DATA(MAX_DATA)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgRole(cfgRole),
    .stepArm(stepArm), .resume(resume),
    .issueValid(issueValid), .retireValid(retireValid),
    .retireRd(retireRd), .retireWr(retireWr), .retireFlow(retireFlow),
    .progEq(progEq), .dataEq(dataEq), .pcMaskHit(pcMaskHit),
    .dataMaskHit(dataMaskHit), .stepMoved(stepMoved), .dataInRf(dataInRf),
    .strb(strb), .haltReq(haltReq), .haltPre(haltPre), .halted(halted),
    .haltCause(haltCause), .cfgErr(cfgErr)
  );
endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk
  import brk_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               resume,
  input logic               retireValid,
  input logic               retireFlow,
  input logic               haltReq,
  input logic               haltPre,
  input logic               halted,
  input logic [CAUSE_W-1:0] haltCause
);
  // R9
  halt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    haltReq |=> halted);

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !resume |=> halted && $stable(haltCause));

  // R9
  resume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted && resume |=> !halted && haltCause == '0);

  // R9
  quiet_while_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !haltReq);

  // R3
  pre_implies_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    haltPre |-> haltReq);

  // R8
  step_cause_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(haltCause[STEP_BIT]) |-> $past(haltPre));

  // R7
  flow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(haltCause[FLOW_BIT]) |-> $past(retireValid && retireFlow));
endmodule

bind brk_unit brk_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .resume(resume),
  .retireValid(retireValid), .retireFlow(retireFlow),
  .haltReq(haltReq), .haltPre(haltPre), .halted(halted),
  .haltCause(haltCause)
);

// File: tb/brk_unit_test.sv
module brk_unit_test;
  import brk_pkg::*;
  localparam int AW = 16;
  localparam int CW = CAUSE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWe = 1'b0;
  logic [SEL_W-1:0] cfgSlot = '0;
  logic [2:0] cfgRole = '0;
  logic [AW-1:0] cfgAddr = '0, cfgMask = '0, stepPc = '0;
  logic stepArm = 1'b0, resume = 1'b0;
  logic issueValid = 1'b0, retireValid = 1'b0;
  logic [AW-1:0] issuePc = '0, retirePc = '0, retireDAddr = '0;
  logic retireRd = 1'b0, retireWr = 1'b0, retireFlow = 1'b0;
  logic haltReq, haltPre, halted, cfgErr;
  logic [CW-1:0] haltCause;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 20 ns period, 50 MHz

  brk_unit uut (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgSlot(cfgSlot),
    .cfgRole(cfgRole), .cfgAddr(cfgAddr), .cfgMask(cfgMask),
    .stepArm(stepArm), .stepPc(stepPc), .resume(resume),
    .issueValid(issueValid), .issuePc(issuePc),
    .retireValid(retireValid), .retirePc(retirePc),
    .retireDAddr(retireDAddr), .retireRd(retireRd), .retireWr(retireWr),
    .retireFlow(retireFlow), .haltReq(haltReq), .haltPre(haltPre),
    .halted(halted), .haltCause(haltCause), .cfgErr(cfgErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clearInputs();
    issueValid = 1'b0; retireValid = 1'b0;
    retireRd = 1'b0; retireWr = 1'b0; retireFlow = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [2:0] r,
                     input logic [AW-1:0] a, input logic [AW-1:0] m);
    @(negedge clk);
    cfgWe = 1'b1; cfgSlot = s; cfgRole = r; cfgAddr = a; cfgMask = m;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // inputs already driven at this negedge
  task automatic finishCycle(input logic expPre, input logic [CW-1:0] expCause, input string tag);
    #2;
    check({tag, " haltReq"}, 32'(haltReq), 32'(expCause != '0));
    check({tag, " haltPre"}, 32'(haltPre), 32'(expPre));
    @(negedge clk);
    clearInputs();
    check({tag, " cause"}, 32'(haltCause), 32'(expCause));
    check({tag, " halted"}, 32'(halted), 32'(expCause != '0));
    if (expCause != '0) begin
      resume = 1'b1;
      @(negedge clk);
      resume = 1'b0;
    end
  endtask

  task automatic runIssue(input logic [AW-1:0] pc, input logic expPre,
                          input logic [CW-1:0] expCause, input string tag);
    @(negedge clk);
    issueValid = 1'b1; issuePc = pc;
    finishCycle(expPre, expCause, tag);
  endtask

  task automatic runRetire(input logic [AW-1:0] pc, input logic [AW-1:0] da,
                           input logic rd, input logic wr, input logic fl,
                           input logic [CW-1:0] expCause, input string tag);
    @(negedge clk);
    retireValid = 1'b1; retirePc = pc; retireDAddr = da;
    retireRd = rd; retireWr = wr; retireFlow = fl;
    finishCycle(1'b0, expCause, tag);
  endtask

  task automatic clearAll();
    cfg(2'd0, 3'd0, '0, '0);
    cfg(2'd1, 3'd0, '0, '0);
    cfg(2'd2, 3'd0, '0, '0);
    cfg(2'd3, 3'd0, '0, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 haltReq", 32'(haltReq), 0);
    check("R1 halted", 32'(halted), 0);
    check("R1 cause", 32'(haltCause), 0);
    check("R1 cfgErr", 32'(cfgErr), 0);
    runIssue(16'h0000, 1'b0, '0, "R1 idle pc0");
    runRetire(16'h0000, 16'h0040, 1'b1, 1'b1, 1'b1, '0, "R1 idle retire");

    // R2 R3 program sweep
    cfg(2'd0, 3'd1, 16'h0120, '0);
    check("R2 accept", 32'(cfgErr), 0);
    for (int p = 16'h0118; p < 16'h0128; p++) begin
      logic hit;
      hit = (p == 16'h0120);
      runIssue(AW'(p), hit, hit ? CW'(1) : CW'(0), "R3 prog");
    end

    // R4 data modes on slot 1
    for (int m = 2; m <= 4; m++) begin
      cfg(2'd1, 3'(m), 16'h0080, '0);
      for (int a = 16'h0080; a <= 16'h0081; a++) begin
        for (int rw = 0; rw < 4; rw++) begin
          logic rd, wr, ok;
          rd = rw[0]; wr = rw[1];
          ok = (m == 2) ? rd : (m == 3) ? wr : (rd | wr);
          ok = ok && (a == 16'h0080);
          runRetire(16'h0200, AW'(a), rd, wr, 1'b0, ok ? CW'(2) : CW'(0), "R4 data");
        end
      end
    end

    // R5 register-file region never matches
    cfg(2'd1, 3'd4, 16'h0010, '0);
    for (int rw = 1; rw < 4; rw++)
      runRetire(16'h0200, 16'h0010, rw[0], rw[1], 1'b0, '0, "R5 rf data");

    // R7 flow
    cfg(2'd3, 3'd1, '0, '0);
    runRetire(16'h0300, 16'h0100, 1'b0, 1'b0, 1'b1, CW'(1 << FLOW_BIT), "R7 flow");
    @(negedge clk);
    retireFlow = 1'b1; #2;
    check("R7 no retire", 32'(haltReq), 0);
    clearInputs();
    cfg(2'd3, 3'd0, '0, '0);
    runRetire(16'h0300, 16'h0100, 1'b0, 1'b0, 1'b1, '0, "R7 off");

    // R8 single step
    @(negedge clk);
    stepArm = 1'b1; stepPc = 16'h0100;
    @(negedge clk);
    stepArm = 1'b0;
    runIssue(16'h0100, 1'b0, '0, "R8 same pc");
    runIssue(16'h0102, 1'b1, CW'(1 << STEP_BIT), "R8 moved");
    runIssue(16'h0104, 1'b0, '0, "R8 disarmed");

    // R10 R12 data limit
    clearAll();
    cfg(2'd0, 3'd2, 16'h0100, '0);
    cfg(2'd1, 3'd3, 16'h0200, '0);
    cfg(2'd2, 3'd1, 16'h0300, '0);
    check("R10 pre err", 32'(cfgErr), 0);
    cfg(2'd2, 3'd4, 16'h0400, '0);
    check("R10 third data err", 32'(cfgErr), 1);
    runIssue(16'h0300, 1'b1, CW'(4), "R12 slot2 kept");
    runRetire(16'h0000, 16'h0400, 1'b1, 1'b1, 1'b0, '0, "R12 no new data");
    runRetire(16'h0000, 16'h0200, 1'b0, 1'b1, 1'b0, CW'(2), "R12 slot1 kept");

    // R9 quiet while halted
    @(negedge clk);
    issueValid = 1'b1; issuePc = 16'h0300; #2;
    check("R9 first req", 32'(haltReq), 1);
    @(negedge clk); #2;
    check("R9 halted", 32'(halted), 1);
    check("R9 quiet", 32'(haltReq), 0);
    check("R9 cause held", 32'(haltCause), 4);
    @(negedge clk);
    clearInputs(); resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    check("R9 resumed", 32'(halted), 0);
    check("R9 cause clr", 32'(haltCause), 0);

    // R11 pairing rules
    cfg(2'd0, 3'd5, 16'h0240, 16'hFFF0);
    check("R11 partner busy", 32'(cfgErr), 1);
    cfg(2'd2, 3'd5, 16'h0240, 16'hFFF0);
    check("R11 last slot", 32'(cfgErr), 1);
    runRetire(16'h0000, 16'h0100, 1'b1, 1'b0, 1'b0, CW'(1), "R12 slot0 kept");
    cfg(2'd1, 3'd0, '0, '0);
    check("R12 accept clears", 32'(cfgErr), 0);
    cfg(2'd0, 3'd5, 16'h0240, 16'hFFF0);
    check("R11 pair ok", 32'(cfgErr), 0);
    cfg(2'd1, 3'd1, 16'h0600, '0);
    check("R11 mask half", 32'(cfgErr), 1);
    cfg(2'd2, 3'd7, 16'h0300, '0);
    check("R11 code7", 32'(cfgErr), 1);
    runIssue(16'h0300, 1'b1, CW'(4), "R12 code7 kept");

    // R6 masked on PC, range sweep
    for (int p = 16'h0230; p < 16'h0260; p++) begin
      logic hit;
      hit = (((p ^ 16'h0240) & 16'hFFF0) == 0);
      runRetire(AW'(p), 16'h0040, 1'b0, 1'b0, 1'b0, hit ? CW'(1) : CW'(0), "R6 mask range");
    end
    cfg(2'd0, 3'd5, 16'h0244, 16'hFFFF);
    for (int p = 16'h0240; p < 16'h0248; p++)
      runRetire(AW'(p), 16'h0040, 1'b0, 1'b0, 1'b0, (p == 16'h0244) ? CW'(1) : CW'(0), "R6 mask ones");

    // R13 break pair, partner freed
    cfg(2'd0, 3'd1, 16'h0500, '0);
    cfg(2'd1, 3'd1, 16'h0600, '0);
    check("R13 partner free", 32'(cfgErr), 0);
    runIssue(16'h0600, 1'b1, CW'(2), "R13 partner fires");
    runIssue(16'h0500, 1'b1, CW'(1), "R13 base fires");

    // R5 R6 masked data, all-zero mask across the register-file edge
    cfg(2'd1, 3'd0, '0, '0);
    cfg(2'd2, 3'd0, '0, '0);
    cfg(2'd0, 3'd6, 16'h0000, 16'h0000);
    for (int a = 0; a < 64; a++)
      runRetire(16'h0000, AW'(a), a[0] == 1'b0, a[0] == 1'b1, 1'b0,
                (a >= 32) ? CW'(1) : CW'(0), "R5 R6 mask data");
    runRetire(16'h0000, 16'h0050, 1'b0, 1'b0, 1'b0, '0, "R6 no access");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule